// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits beside the CPU of a small 16-bit microcontroller and picks the one request that the core should service next. It collects reset causes, a class of interrupts that only their own enable bits can hold off, and ordinary maskable interrupts that also need the global enable from the status register. It turns the winner into a word address in the vector table, where address = 16'hFFC0 + 2 × priority, for priorities 0 to 31.

The block also holds the small system flag and enable registers. Their bits take separate values at power-on reset (POR) and at a power-up clear (PUC), which any reset cause triggers. Once the core has fetched the reset vector, the block requests the deepest low-power state if that word is blank. The request and vector are registered and stay fixed until the core acknowledges them. On acknowledge the block pulses a request to clear the global enable.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Register offsets on `reg_addr` work as follows. Offset 0 holds the system enables: bit0 watchdog-interval enable, bit1 oscillator-fault enable, bit4 pin-NMI enable, bit5 access-violation enable. Offset 1 holds the serial enables. Offset 2 holds the system flags: bit0 watchdog, bit1 oscillator fault, bit2 power-on, bit3 pin reset, bit4 pin NMI. Offset 3 holds the serial flags, with bit0/bit2 receive and bit1/bit3 transmit. The serial enables use the same bit positions as the serial flags. Bits that are not implemented read 0 and ignore writes, so the read masks are 0x33, 0x0F, 0x1F and 0x0F.
- R2: After POR the four registers read 0x00, 0x00, 0x06 and 0x0A. `rst_req`, `irq_req` and `lpm_req` are low.
- R3: Each of these reset causes makes `rst_req` high for exactly the next cycle, with `irq_vec` = 0xFFFE and `irq_req` low:
  - the pin reset
  - watchdog overflow
  - key violation
  - a valid fetch below 0x0200 or inside 0x1100..0x7FFF
- R4: A reset cause (PUC) clears both enable registers, sets the serial flags to 0x0A, sets the oscillator-fault flag, clears the pin-NMI flag, and leaves the power-on flag unchanged.
- R5: The pin-reset flag is set by the pin reset and is not cleared by any PUC. The watchdog flag is set by a watchdog overflow or a key violation, and is cleared by a pin reset.
- R6: The oscillator-fault, pin-NMI and access-violation sources share priority 30 (vector 0xFFFC). Each is gated only by its own enable, never by `gie`.
- R7: `periph_irq` bits 0..6 map to priorities 18, 19, 21, 24, 25, 28 and 29. They need `gie` high to request.
- R8: The highest pending priority wins, and `irq_vec` = 0xFFC0 + 2 × priority.
- R9: The serial receive flags request priority 23 (0xFFEE) and the transmit flags request priority 22 (0xFFEC). Each flag needs its own enable and `gie`.
- R10: The watchdog flag requests priority 26 (0xFFF4) only when its enable, `wdt_intv_mode` and `gie` are all high.
- R11: A request is latched on the clock edge after it appears. `irq_req` and `irq_vec` then hold, even against higher requests, until `irq_ack`.
- R12: While `irq_req` is high, `irq_ack` drops `irq_req` at the next edge and makes `gie_clear` high for one cycle. For a priority-30 entry it also clears enable bits 1, 4 and 5.
- R13: A reset-vector word of 0xFFFF presented with `rv_valid` sets `lpm_req`. Any other word clears it, and so does a reset cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| pin_rst | input | 1 | Reset pin event, one-cycle pulse |
| wdt_ovf | input | 1 | Watchdog overflow in watchdog mode |
| key_viol | input | 1 | Flash key violation |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 16 | Fetch address |
| rv_valid | input | 1 | Reset vector word is valid |
| rv_data | input | 16 | Reset vector word |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| osc_fault | input | 1 | Oscillator fault level, sets its flag |
| nmi_evt | input | 1 | Pin NMI event, sets its flag |
| wdt_intv_mode | input | 1 | Watchdog runs as an interval timer |
| wdt_intv_evt | input | 1 | Interval expiry, sets the watchdog flag |
| acc_viol | input | 1 | Flash access violation flag (level) |
| periph_irq | input | 7 | Peripheral requests, already gated by their own enables |
| ser_set | input | 4 | Serial flag set pulses, same bit layout as offset 3 |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | CPU acknowledge |
| rst_req | output | 1 | Reset request pulse |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 16 | Vector word address |
| gie_clear | output | 1 | Pulse asking the CPU to clear the global enable |
| lpm_req | output | 1 | Enter deepest low-power state |

## Verification
Every output except `reg_rdata` comes from a register. A reset cause, an acknowledge or a winning request sampled at one edge therefore shows up just after that edge. The bench drives inputs one time unit after a rising edge, and reads outputs one time unit after the next rising edge. It allows a second cycle wherever a level input has to pass through the arbitration first. Register reads are combinational, so they are checked in the same cycle as the address. Writes are checked in the cycle after the write edge.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int NUM_PRIO = 32;
    localparam int PRIO_W   = $clog2(NUM_PRIO);

    localparam int PRIO_RESET = 31;
    localparam int PRIO_NMI   = 30;
    localparam int PRIO_WDT   = 26;
    localparam int PRIO_RX    = 23;
    localparam int PRIO_TX    = 22;

    localparam int N_PERIPH = 7;
    localparam int PERIPH_PRIO [N_PERIPH] = '{18, 19, 21, 24, 25, 28, 29};

    // system enable / flag bit positions
    localparam int B_WDT  = 0;
    localparam int B_OF   = 1;
    localparam int B_POR  = 2;
    localparam int B_RST  = 3;
    localparam int B_NMI  = 4;
    localparam int B_ACCV = 5;

    localparam logic [7:0] SEN_MASK   = 8'h33;
    localparam logic [7:0] SFLG_MASK  = 8'h1F;
    localparam logic [7:0] SER_MASK   = 8'h0F;
    localparam logic [7:0] NMI_EN_MSK = 8'h32;
    localparam logic [7:0] SER_PUC    = 8'h0A;

    typedef struct packed {
        logic [7:0] sen;   // offset 0
        logic [7:0] ser_en;   // offset 1
        logic [7:0] sflg;  // offset 2
        logic [7:0] ser_flg;  // offset 3
    } sfr_t;

    localparam sfr_t SFR_POR = '{sen: 8'h00, ser_en: 8'h00, sflg: 8'h06, ser_flg: 8'h0A};

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_RESET = 2'd1,
        CLS_NMI   = 2'd2,
        CLS_MASK  = 2'd3
    } cls_e;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irq_sfr_regs.sv
module irq_sfr_regs
    import irq_vec_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       puc,
    input  logic       pin_rst,
    input  logic       wdt_flag_rst,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       osc_fault,
    input  logic       nmi_evt,
    input  logic       wdt_intv_evt,
    input  logic [3:0] ser_set,
    input  logic       nmi_ack,
    output sfr_t       sfr
);
    sfr_t d, q;

    always_comb begin
        d = q;
        if (reg_wr) begin
            case (reg_addr)
                2'd0: d.sen     = reg_wdata & SEN_MASK;
                2'd1: d.ser_en  = reg_wdata & SER_MASK;
                2'd2: d.sflg    = reg_wdata & SFLG_MASK;
                2'd3: d.ser_flg = reg_wdata & SER_MASK;
            endcase
        end
        // hardware set events win over a same-cycle software write
        d.sflg[B_OF]  = d.sflg[B_OF]  | osc_fault;
        d.sflg[B_NMI] = d.sflg[B_NMI] | nmi_evt;
        d.sflg[B_WDT] = d.sflg[B_WDT] | wdt_intv_evt;
        d.ser_flg     = d.ser_flg | {4'b0000, ser_set};
        if (nmi_ack) d.sen = d.sen & ~NMI_EN_MSK;
        if (puc) begin
            d.sen          = 8'h00;
            d.ser_en       = 8'h00;
            d.ser_flg      = SER_PUC;
            d.sflg         = 8'h00;
            d.sflg[B_OF]   = 1'b1;
            d.sflg[B_POR]  = q.sflg[B_POR];
            d.sflg[B_RST]  = q.sflg[B_RST] | pin_rst;
            d.sflg[B_WDT]  = wdt_flag_rst ? 1'b1 : (pin_rst ? 1'b0 : q.sflg[B_WDT]);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q <= SFR_POR;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            2'd0:    reg_rdata = q.sen;
            2'd1:    reg_rdata = q.ser_en;
            2'd2:    reg_rdata = q.sflg;
            default: reg_rdata = q.ser_flg;
        endcase
    end

    assign sfr = q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter int          AW        = 16,
    parameter logic [AW-1:0] SFR_END   = 16'h0200,
    parameter logic [AW-1:0] UNUSED_LO = 16'h1100,
    parameter logic [AW-1:0] UNUSED_HI = 16'h7FFF
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          pin_rst,
    input  logic          wdt_ovf,
    input  logic          key_viol,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    input  logic          rv_valid,
    input  logic [AW-1:0] rv_data,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          osc_fault,
    input  logic          nmi_evt,
    input  logic          wdt_intv_mode,
    input  logic          wdt_intv_evt,
    input  logic          acc_viol,
    input  logic [6:0]    periph_irq,
    input  logic [3:0]    ser_set,
    input  logic          gie,
    input  logic          irq_ack,
    output logic          rst_req,
    output logic          irq_req,
    output logic [AW-1:0] irq_vec,
    output logic          gie_clear,
    output logic          lpm_req
);
    localparam logic [AW-1:0] VEC_BASE  = AW'(16'hFFC0);
    localparam logic [AW-1:0] RESET_VEC = VEC_BASE + AW'(2 * PRIO_RESET);
    localparam logic [AW-1:0] BLANK     = '1;

    typedef struct packed {
        logic          rst_req;
        logic          irq;
        logic [AW-1:0] vec;
        cls_e          cls;
        logic          gie_clr;
        logic          lpm;
    } ctl_t;

    ctl_t d, q;

    logic                fetch_bad, rst_src, nmi_ack;
    logic [NUM_PRIO-1:0] req;
    logic                win_any;
    logic [PRIO_W-1:0]   win_idx;
    sfr_t                sfr;

    assign fetch_bad = fetch_valid &&
                       ((fetch_addr < SFR_END) ||
                        ((fetch_addr >= UNUSED_LO) && (fetch_addr <= UNUSED_HI)));
    assign rst_src   = pin_rst | wdt_ovf | key_viol | fetch_bad;
    assign nmi_ack   = q.irq & irq_ack & (q.cls == CLS_NMI) & ~rst_src;

    irq_sfr_regs u_sfr (
        .clk          (clk),
        .por_n        (por_n),
        .puc          (rst_src),
        .pin_rst      (pin_rst),
        .wdt_flag_rst (wdt_ovf | key_viol),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .osc_fault    (osc_fault),
        .nmi_evt      (nmi_evt),
        .wdt_intv_evt (wdt_intv_evt),
        .ser_set      (ser_set),
        .nmi_ack      (nmi_ack),
        .sfr          (sfr)
    );

    // request map: one bit per priority level
    always_comb begin
        req = '0;
        req[PRIO_NMI] = (sfr.sflg[B_OF]  & sfr.sen[B_OF])  |
                        (sfr.sflg[B_NMI] & sfr.sen[B_NMI]) |
                        (acc_viol        & sfr.sen[B_ACCV]);
        for (int i = 0; i < N_PERIPH; i++) begin
            req[PERIPH_PRIO[i]] = periph_irq[i] & gie;
        end
        req[PRIO_WDT] = sfr.sflg[B_WDT] & sfr.sen[B_WDT] & wdt_intv_mode & gie;
        req[PRIO_RX]  = ((sfr.ser_flg[0] & sfr.ser_en[0]) |
                         (sfr.ser_flg[2] & sfr.ser_en[2])) & gie;
        req[PRIO_TX]  = ((sfr.ser_flg[1] & sfr.ser_en[1]) |
                         (sfr.ser_flg[3] & sfr.ser_en[3])) & gie;
    end

    irq_prio_enc #(.N(NUM_PRIO), .IW(PRIO_W)) u_enc (
        .req (req),
        .any (win_any),
        .idx (win_idx)
    );

    always_comb begin
        d         = q;
        d.rst_req = 1'b0;
        d.gie_clr = 1'b0;
        if (rst_src) begin
            d.rst_req = 1'b1;
            d.irq     = 1'b0;
            d.vec     = RESET_VEC;
            d.cls     = CLS_RESET;
            d.lpm     = 1'b0;
        end else begin
            if (q.irq) begin
                if (irq_ack) begin
                    d.irq     = 1'b0;
                    d.gie_clr = 1'b1;
                end
            end else if (win_any) begin
                d.irq = 1'b1;
                d.vec = VEC_BASE + AW'({win_idx, 1'b0});
                d.cls = (int'(win_idx) == PRIO_NMI) ? CLS_NMI : CLS_MASK;
            end
            if (rv_valid) d.lpm = (rv_data == BLANK);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q <= '{rst_req: 1'b0, irq: 1'b0, vec: RESET_VEC, cls: CLS_NONE,
                   gie_clr: 1'b0, lpm: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign rst_req   = q.rst_req;
    assign irq_req   = q.irq;
    assign irq_vec   = q.vec;
    assign gie_clear = q.gie_clr;
    assign lpm_req   = q.lpm;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
    parameter int            AW        = 16,
    parameter logic [AW-1:0] SFR_END   = 16'h0200,
    parameter logic [AW-1:0] UNUSED_LO = 16'h1100,
    parameter logic [AW-1:0] UNUSED_HI = 16'h7FFF
) (
    input logic          clk,
    input logic          por_n,
    input logic          pin_rst,
    input logic          wdt_ovf,
    input logic          key_viol,
    input logic          fetch_valid,
    input logic [AW-1:0] fetch_addr,
    input logic          irq_ack,
    input logic          rst_req,
    input logic          irq_req,
    input logic [AW-1:0] irq_vec,
    input logic          gie_clear
);
    logic src;
    assign src = pin_rst | wdt_ovf | key_viol |
                 (fetch_valid && ((fetch_addr < SFR_END) ||
                  ((fetch_addr >= UNUSED_LO) && (fetch_addr <= UNUSED_HI))));

    p_rst_pulse_r3: assert property (@(posedge clk) disable iff (!por_n)
        src |=> rst_req && !irq_req && (irq_vec == AW'(16'hFFFE)));

    p_rst_once_r3: assert property (@(posedge clk) disable iff (!por_n)
        rst_req && !src |=> !rst_req);

    p_hold_r11: assert property (@(posedge clk) disable iff (!por_n)
        irq_req && !irq_ack && !src |=> irq_req && $stable(irq_vec));

    p_ack_drop_r12: assert property (@(posedge clk) disable iff (!por_n)
        irq_req && irq_ack && !src |=> !irq_req && gie_clear);

    p_gclr_pulse_r12: assert property (@(posedge clk) disable iff (!por_n)
        gie_clear |=> !gie_clear);

    p_vec_range_r8: assert property (@(posedge clk) disable iff (!por_n)
        irq_req |-> (irq_vec[0] == 1'b0) && (irq_vec >= AW'(16'hFFC0)) &&
                    (irq_vec != AW'(16'hFFFE)));

    p_excl_r11: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({rst_req, irq_req, gie_clear}));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
    .AW(AW), .SFR_END(SFR_END), .UNUSED_LO(UNUSED_LO), .UNUSED_HI(UNUSED_HI)
) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .pin_rst     (pin_rst),
    .wdt_ovf     (wdt_ovf),
    .key_viol    (key_viol),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .irq_ack     (irq_ack),
    .rst_req     (rst_req),
    .irq_req     (irq_req),
    .irq_vec     (irq_vec),
    .gie_clear   (gie_clear)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
    logic        clk = 1'b0;
    logic        por_n, pin_rst, wdt_ovf, key_viol, fetch_valid, rv_valid;
    logic [15:0] fetch_addr, rv_data;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        osc_fault, nmi_evt, wdt_intv_mode, wdt_intv_evt, acc_viol;
    logic [6:0]  periph_irq;
    logic [3:0]  ser_set;
    logic        gie, irq_ack, rst_req, irq_req, gie_clear, lpm_req;
    logic [15:0] irq_vec;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .por_n(por_n), .pin_rst(pin_rst), .wdt_ovf(wdt_ovf),
        .key_viol(key_viol), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .rv_valid(rv_valid), .rv_data(rv_data), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .osc_fault(osc_fault), .nmi_evt(nmi_evt), .wdt_intv_mode(wdt_intv_mode),
        .wdt_intv_evt(wdt_intv_evt), .acc_viol(acc_viol), .periph_irq(periph_irq),
        .ser_set(ser_set), .gie(gie), .irq_ack(irq_ack), .rst_req(rst_req),
        .irq_req(irq_req), .irq_vec(irq_vec), .gie_clear(gie_clear),
        .lpm_req(lpm_req)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] e);
        reg_addr = a;
        #1;
        chk(tag, 32'(reg_rdata), 32'(e));
    endtask

    task automatic try_fetch(input logic [15:0] a, input logic e);
        fetch_valid = 1'b1; fetch_addr = a;
        step();
        fetch_valid = 1'b0;
        chk("R3 fetch range", 32'(rst_req), 32'(e));
        step();
    endtask

    task automatic ack_once();
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
    endtask

    // expected winner: bit 16 = valid, bits 15:0 = vector
    function automatic logic [16:0] exp_win(input logic [7:0] e1, input logic [7:0] e2,
                                            input logic [7:0] f1, input logic [7:0] f2,
                                            input logic [6:0] pi, input logic g,
                                            input logic wm, input logic av);
        int best = -1;
        int pr [7] = '{18, 19, 21, 24, 25, 28, 29};
        if ((f1[1] & e1[1]) | (f1[4] & e1[4]) | (av & e1[5])) best = 30;
        if (g) begin
            for (int i = 0; i < 7; i++)
                if (pi[i] && pr[i] > best) best = pr[i];
            if (f1[0] && e1[0] && wm && best < 26) best = 26;
            if (((f2[0] & e2[0]) | (f2[2] & e2[2])) && best < 23) best = 23;
            if (((f2[1] & e2[1]) | (f2[3] & e2[3])) && best < 22) best = 22;
        end
        if (best < 0) return 17'h0;
        return {1'b1, 16'(16'hFFC0 + 2 * best)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [16:0] ew;
        por_n = 1'b0; pin_rst = 0; wdt_ovf = 0; key_viol = 0; fetch_valid = 0;
        fetch_addr = 16'h8000; rv_valid = 0; rv_data = 0; reg_wr = 0; reg_addr = 0;
        reg_wdata = 0; osc_fault = 0; nmi_evt = 0; wdt_intv_mode = 0; wdt_intv_evt = 0;
        acc_viol = 0; periph_irq = 0; ser_set = 0; gie = 0; irq_ack = 0;
        void'($urandom(32'd1234));
        repeat (3) step();
        por_n = 1'b1;
        step();

        // R2 power-on values
        rd("R2 sen", 2'd0, 8'h00);
        rd("R2 ser_en", 2'd1, 8'h00);
        rd("R2 sflg", 2'd2, 8'h06);
        rd("R2 ser_flg", 2'd3, 8'h0A);
        chk("R2 rst_req", 32'(rst_req), 0);
        chk("R2 irq_req", 32'(irq_req), 0);
        chk("R2 lpm_req", 32'(lpm_req), 0);

        // R1 unimplemented bits
        wr(2'd0, 8'hFF); rd("R1 mask0", 2'd0, 8'h33);
        wr(2'd2, 8'hFF); rd("R1 mask2", 2'd2, 8'h1F);
        wr(2'd1, 8'hFF); rd("R1 mask1", 2'd1, 8'h0F);
        wr(2'd3, 8'hFF); rd("R1 mask3", 2'd3, 8'h0F);

        // R6 priority-30 entry while gie is low
        step();
        chk("R6 irq_req", 32'(irq_req), 1);
        chk("R6 vec", 32'(irq_vec), 32'h0000FFFC);

        // R12 acknowledge of a priority-30 entry
        ack_once();
        chk("R12 irq drop", 32'(irq_req), 0);
        chk("R12 gie_clear", 32'(gie_clear), 1);
        rd("R12 nmi enables cleared", 2'd0, 8'h01);
        step();
        chk("R12 gie_clear pulse", 32'(gie_clear), 0);

        // R3/R4/R5 pin reset
        wr(2'd2, 8'h15);
        pin_rst = 1'b1; step(); pin_rst = 1'b0;
        chk("R3 rst_req", 32'(rst_req), 1);
        chk("R3 vec", 32'(irq_vec), 32'h0000FFFE);
        chk("R3 irq low", 32'(irq_req), 0);
        rd("R5 pin flags", 2'd2, 8'h0E);
        rd("R4 sen", 2'd0, 8'h00);
        rd("R4 ser_en", 2'd1, 8'h00);
        rd("R4 ser_flg", 2'd3, 8'h0A);
        step();
        chk("R3 one cycle", 32'(rst_req), 0);

        // R5 watchdog overflow keeps pin flag
        wdt_ovf = 1'b1; step(); wdt_ovf = 1'b0;
        chk("R3 wdt rst", 32'(rst_req), 1);
        rd("R5 wdt flag", 2'd2, 8'h0F);
        step();
        wr(2'd2, 8'h00);
        key_viol = 1'b1; step(); key_viol = 1'b0;
        chk("R3 key rst", 32'(rst_req), 1);
        rd("R5 key flag", 2'd2, 8'h03);
        step();

        // R3 fetch ranges
        try_fetch(16'h0100, 1'b1);
        try_fetch(16'h01FF, 1'b1);
        try_fetch(16'h0200, 1'b0);
        try_fetch(16'h10FF, 1'b0);
        try_fetch(16'h1100, 1'b1);
        try_fetch(16'h7FFF, 1'b1);
        try_fetch(16'h8000, 1'b0);

        // R13 blank reset vector
        rv_valid = 1'b1; rv_data = 16'hFFFF; step(); rv_valid = 1'b0;
        chk("R13 blank", 32'(lpm_req), 1);
        rv_valid = 1'b1; rv_data = 16'h8000; step(); rv_valid = 1'b0;
        chk("R13 programmed", 32'(lpm_req), 0);
        rv_valid = 1'b1; rv_data = 16'hFFFF; step(); rv_valid = 1'b0;
        pin_rst = 1'b1; step(); pin_rst = 1'b0;
        chk("R13 reset clears", 32'(lpm_req), 0);
        step();

        // R7/R8 maskable peripherals
        wr(2'd2, 8'h00);
        periph_irq = 7'h7F; step(); step();
        chk("R7 gie gate", 32'(irq_req), 0);
        gie = 1'b1; step(); step();
        chk("R8 highest", 32'(irq_vec), 32'h0000FFFA);
        periph_irq = 7'h01;
        ack_once(); chk("R12 drop", 32'(irq_req), 0);
        step(); step();
        chk("R7 port1", 32'(irq_vec), 32'h0000FFE4);

        // R11 hold against higher request
        periph_irq = 7'h41; step(); step();
        chk("R11 hold", 32'(irq_vec), 32'h0000FFE4);
        ack_once(); step(); step();
        chk("R11 next winner", 32'(irq_vec), 32'h0000FFFA);
        periph_irq = 7'h00;
        ack_once(); step();

        // R9 serial
        wr(2'd1, 8'h0F); step();
        chk("R9 tx", 32'(irq_vec), 32'h0000FFEC);
        ser_set = 4'b0001; step(); ser_set = 4'b0000;
        ack_once(); step(); step();
        chk("R9 rx", 32'(irq_vec), 32'h0000FFEE);
        wr(2'd3, 8'h00);
        ack_once(); step();
        chk("R9 cleared", 32'(irq_req), 0);
        wr(2'd1, 8'h00);

        // R10 watchdog interval request
        wr(2'd2, 8'h01); wr(2'd0, 8'h01);
        step(); step();
        chk("R10 mode gate", 32'(irq_req), 0);
        wdt_intv_mode = 1'b1; step(); step();
        chk("R10 interval", 32'(irq_vec), 32'h0000FFF4);
        wdt_intv_mode = 1'b0;
        ack_once(); wr(2'd0, 8'h00); gie = 1'b0; step();

        // random mix, R7 R8 R6 R9 R10 R12
        for (int it = 0; it < 300; it++) begin
            logic [7:0] e1, e2, f1, f2;
            logic [6:0] pi;
            logic g, wm, av;
            e1 = 8'($urandom) & 8'h33; e2 = 8'($urandom) & 8'h0F;
            f1 = 8'($urandom) & 8'h13; f2 = 8'($urandom) & 8'h0F;
            pi = 7'($urandom); g = 1'($urandom); wm = 1'($urandom); av = 1'($urandom);
            if (it % 4 == 0) pi = 7'h00;
            gie = 1'b0; periph_irq = 0; acc_viol = 0; wdt_intv_mode = 0;
            wr(2'd0, 8'h00); wr(2'd1, 8'h00);
            wr(2'd2, f1); wr(2'd3, f2); wr(2'd1, e2); wr(2'd0, e1);
            gie = g; periph_irq = pi; wdt_intv_mode = wm; acc_viol = av;
            step(); step();
            ew = exp_win(e1, e2, f1, f2, pi, g, wm, av);
            chk("R8 random req", 32'(irq_req), 32'(ew[16]));
            if (ew[16]) chk("R7 random vec", 32'(irq_vec), 32'(ew[15:0]));
            gie = 1'b0; periph_irq = 0; acc_viol = 0; wdt_intv_mode = 0;
            if (irq_req) begin
                ack_once();
                chk("R12 random ack", 32'({irq_req, gie_clear}), 32'h1);
            end else begin
                step();
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule